// File: doc/BRIEF.md
# Coprocessor Instruction Retirement Controller

This block sits at the bottom of a coprocessor pipeline and decides, cycle by cycle, whether the instruction leaving the first execute stage may retire. It takes a decoded instruction class, a valid flag, and two availability flags. One flag says that the finish queue holds a token. The other says that the load data path from the core holds a word. From these it produces a retire strobe, a final-beat flag, a stall for the first execute stage, and one-cycle pop strobes toward whichever source was used.

Each class has its own rule. A data-processing operation waits for a finish token. A transfer from the coprocessor toward the core is a store: it needs no token and retires at once. A transfer from the core into the coprocessor is a load: it waits for a load data word for every beat it moves. A pair load moves two beats. A memory load moves a beat count given with the instruction. The controller counts beats, so a multi-beat load retires one beat per available word and raises the final-beat flag only on the last one.

The outputs are combinational from the inputs and one beat counter. The upstream stage must hold the instruction steady while the stall is high.

Top module: `cp_retire_ctrl`

## Requirements
- R1: After a synchronous active-low reset the beat counter is cleared. With the valid flag low, every output (retire_beat, retire_last, fin_tok_pop, ld_data_pop, ex1_stall) is low.
- R2: Class code 0 (data-processing) retires only in a cycle where fin_tok_avail is high. In that cycle retire_beat, retire_last and fin_tok_pop are all high. Otherwise all three are low and ex1_stall is high.
- R3: Class codes 1, 2 and 3 (single-register, register-pair and memory stores) retire in the first cycle they are valid, whatever the state of both availability flags. retire_beat and retire_last are high, and ex1_stall and both pops are low.
- R4: Class code 4 (single-register load) retires only when ld_data_avail is high. It raises retire_beat, retire_last and ld_data_pop together; otherwise it stalls.
- R5: Class code 5 (register-pair load) takes two beats. Each beat needs ld_data_avail and pulses ld_data_pop. retire_last is high only on the second beat.
- R6: Class code 6 (memory load) takes ex1_extra+1 beats, each gated by ld_data_avail. retire_last is high on the final beat only, and ex1_extra = 0 gives a single beat.
- R7: ex1_stall is high exactly when ex1_valid is high and retire_last is low. This includes non-final beats of a multi-beat load.
- R8: fin_tok_pop never rises for a load or store, and ld_data_pop never rises for a data-processing operation or store. The two pops are never high together.
- R9: Class code 7 is reserved. It retires at once like a store and pops neither source.
- R10: A cycle in which a load's data is absent retires no beat and does not advance the beat count. The load resumes where it stopped once data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex1_valid | input | 1 | An instruction occupies the first execute stage |
| ex1_class | input | 3 | Decoded instruction class code |
| ex1_extra | input | CNT_W | Extra beats of a memory load (beats = value + 1) |
| fin_tok_avail | input | 1 | Finish queue holds a token |
| ld_data_avail | input | 1 | Load data path holds a word |
| retire_beat | output | 1 | One beat of the current instruction retires this cycle |
| retire_last | output | 1 | The final beat retires; the instruction leaves |
| fin_tok_pop | output | 1 | Consume one finish token |
| ld_data_pop | output | 1 | Consume one load data word |
| ex1_stall | output | 1 | Hold the first execute stage |

## Verification
The only internal state is the beat counter. If it is wrong, retire_last appears too early or too late within a multi-beat load. That shows up at the ports in the same cycle as the faulty beat: the stall drops early, or one beat too many pops the data path. A counter left non-zero after an instruction leaves shows up only in the next multi-beat load, which then ends short. The bench therefore runs several multi-beat loads back to back and checks every beat. A counter that moves on a data-absent cycle shows up as a shortened load, so gaps are placed in the middle of loads.

// File: rtl/cp_retire_pkg.sv
// Package: shared class codes for the retirement controller.
// Assumes a 3-bit class field produced by the decode stage.
package cp_retire_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_DP      = 3'd0,
        CLS_ST_REG  = 3'd1,
        CLS_ST_PAIR = 3'd2,
        CLS_ST_MEM  = 3'd3,
        CLS_LD_REG  = 3'd4,
        CLS_LD_PAIR = 3'd5,
        CLS_LD_MEM  = 3'd6,
        CLS_RSVD    = 3'd7
    } retire_cls_e;

    localparam int PAIR_BEATS = 2;

endpackage

// File: rtl/cp_retire_cond.sv
// Module: cp_retire_cond
// Translates a class code into its retirement condition: which source gates
// each beat and the index of the final beat. Purely combinational.
// Assumes ex1_extra is meaningful only for memory loads.
module cp_retire_cond
    import cp_retire_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CLS_W-1:0] cls,
    input  logic [CNT_W-1:0] extra,
    output logic             need_tok,
    output logic             need_ld,
    output logic [CNT_W-1:0] last_idx
);

    // Select gating source and final-beat index per class.
    always_comb begin
        need_tok = 1'b0;
        need_ld  = 1'b0;
        last_idx = '0;
        unique case (retire_cls_e'(cls))
            CLS_DP: need_tok = 1'b1;
            CLS_LD_REG: need_ld = 1'b1;
            CLS_LD_PAIR: begin
                need_ld  = 1'b1;
                last_idx = CNT_W'(PAIR_BEATS - 1);
            end
            CLS_LD_MEM: begin
                need_ld  = 1'b1;
                last_idx = extra;
            end
            default: ;
        endcase
    end

    // R8
    always_comb begin
        no_dual_need_chk: assert (!(need_tok && need_ld));
    end

endmodule

// File: rtl/cp_retire_beat.sv
// Module: cp_retire_beat
// Counts retired beats of the instruction in the first execute stage and
// flags the final one. Assumes the class and beat count are held stable
// while the instruction stalls.
module cp_retire_beat #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             beat,
    input  logic [CNT_W-1:0] last_idx,
    output logic             at_last
);

    logic [CNT_W-1:0] cnt_q;

    assign at_last = (cnt_q == last_idx);

    // Advance on a non-final beat, clear once the instruction leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (valid && beat) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cnt_q <= last_idx));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && beat && at_last) |=> (cnt_q == '0));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !beat) |=> $stable(cnt_q));

endmodule

// File: rtl/cp_retire_ctrl.sv
// Module: cp_retire_ctrl (top)
// Decides retirement of the instruction leaving the first execute stage.
// It gates each beat on the source its class needs, pops that source and
// stalls the stage until the final beat. Assumes the upstream stage holds
// its inputs stable while ex1_stall is high.
module cp_retire_ctrl
    import cp_retire_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex1_valid,
    input  logic [2:0]       ex1_class,
    input  logic [CNT_W-1:0] ex1_extra,
    input  logic             fin_tok_avail,
    input  logic             ld_data_avail,
    output logic             retire_beat,
    output logic             retire_last,
    output logic             fin_tok_pop,
    output logic             ld_data_pop,
    output logic             ex1_stall
);

    logic             need_tok;
    logic             need_ld;
    logic [CNT_W-1:0] last_idx;
    logic             at_last;
    logic             cond_met;

    cp_retire_cond #(.CNT_W(CNT_W)) u_cond (
        .cls      (ex1_class),
        .extra    (ex1_extra),
        .need_tok (need_tok),
        .need_ld  (need_ld),
        .last_idx (last_idx)
    );

    cp_retire_beat #(.CNT_W(CNT_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (ex1_valid),
        .beat     (retire_beat),
        .last_idx (last_idx),
        .at_last  (at_last)
    );

    // Combine the class condition with source availability into outputs.
    always_comb begin
        cond_met    = (!need_tok || fin_tok_avail) && (!need_ld || ld_data_avail);
        retire_beat = ex1_valid && cond_met;
        retire_last = retire_beat && at_last;
        fin_tok_pop = retire_beat && need_tok;
        ld_data_pop = retire_beat && need_ld;
        ex1_stall   = ex1_valid && !retire_last;
    end

    // R2
    tok_pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_tok_pop |-> fin_tok_avail);

    // R4
    ld_pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_data_pop |-> ld_data_avail);

    // R8
    pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fin_tok_pop, ld_data_pop}));

    // R7
    stall_vs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex1_valid |-> (ex1_stall != retire_last));

endmodule

// File: tb/cp_retire_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module cp_retire_ctrl_bench;

    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ex1_valid = 1'b0;
    logic [2:0]       ex1_class = '0;
    logic [CNT_W-1:0] ex1_extra = '0;
    logic             fin_tok_avail = 1'b0;
    logic             ld_data_avail = 1'b0;
    logic             retire_beat, retire_last, fin_tok_pop, ld_data_pop, ex1_stall;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cp_retire_ctrl #(.CNT_W(CNT_W)) u_cp_retire_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ex1_valid     (ex1_valid),
        .ex1_class     (ex1_class),
        .ex1_extra     (ex1_extra),
        .fin_tok_avail (fin_tok_avail),
        .ld_data_avail (ld_data_avail),
        .retire_beat   (retire_beat),
        .retire_last   (retire_last),
        .fin_tok_pop   (fin_tok_pop),
        .ld_data_pop   (ld_data_pop),
        .ex1_stall     (ex1_stall)
    );

    // Compare the output vector {beat,last,tokpop,ldpop,stall}; then step one cycle.
    task automatic expect_step(input string req, input logic [4:0] exp);
        logic [4:0] got;
        #1;
        got = {retire_beat, retire_last, fin_tok_pop, ld_data_pop, ex1_stall};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic v, input logic [2:0] c, input logic [CNT_W-1:0] x,
                         input logic tok, input logic ld);
        ex1_valid = v; ex1_class = c; ex1_extra = x;
        fin_tok_avail = tok; ld_data_avail = ld;
    endtask

    // R1: reset clears the counter; idle outputs low.
    task automatic t_reset();
        drive(1, 3'd5, '0, 0, 1);
        expect_step("R1 pre-reset beat", 5'b10011);
        rst_n = 1'b0;
        drive(0, 3'd0, '0, 1, 1);
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        expect_step("R1 idle outputs", 5'b00000);
        drive(1, 3'd5, '0, 0, 1);
        expect_step("R1 counter cleared (first pair beat)", 5'b10011);
        expect_step("R1 counter cleared (second pair beat)", 5'b11010);
        drive(0, 3'd0, '0, 0, 0);
    endtask

    // R2, R8: data-processing waits for a token, ignores load data.
    task automatic t_dp();
        drive(1, 3'd0, '0, 0, 1);
        expect_step("R2 dp stalls without token", 5'b00001);
        expect_step("R2 dp still stalled", 5'b00001);
        drive(1, 3'd0, '0, 1, 1);
        expect_step("R2 R8 dp retires with token pop only", 5'b11100);
        drive(0, 3'd0, '0, 0, 0);
    endtask

    // R3, R8: stores retire at once in any availability state.
    task automatic t_stores();
        for (int c = 1; c <= 3; c++) begin
            for (int a = 0; a < 4; a++) begin
                drive(1, 3'(c), 4'd7, a[0], a[1]);
                expect_step($sformatf("R3 R8 store class %0d avail %0d", c, a), 5'b11000);
            end
        end
        drive(0, 3'd0, '0, 0, 0);
    endtask

    // R4: single-register load.
    task automatic t_single_load();
        drive(1, 3'd4, 4'd9, 1, 0);
        expect_step("R4 load stalls without data", 5'b00001);
        drive(1, 3'd4, 4'd9, 1, 1);
        expect_step("R4 load retires with data pop", 5'b11010);
        drive(0, 3'd0, '0, 0, 0);
    endtask

    // R5, R7, R10: pair load with a data gap between beats.
    task automatic t_pair_load();
        drive(1, 3'd5, '0, 0, 1);
        expect_step("R5 R7 pair beat 1 keeps stall", 5'b10011);
        drive(1, 3'd5, '0, 0, 0);
        expect_step("R10 pair gap no beat", 5'b00001);
        drive(1, 3'd5, '0, 0, 1);
        expect_step("R5 pair beat 2 last", 5'b11010);
        drive(0, 3'd0, '0, 0, 0);
    endtask

    // R6, R10: memory load of extra+1 beats with gaps every third beat.
    task automatic t_mem_load(input int extra);
        for (int b = 0; b <= extra; b++) begin
            drive(1, 3'd6, 4'(extra), 1, 1);
            if (b % 3 == 1) begin
                ld_data_avail = 1'b0;
                expect_step($sformatf("R10 mem x%0d gap at beat %0d", extra, b), 5'b00001);
                ld_data_avail = 1'b1;
            end
            expect_step($sformatf("R6 mem x%0d beat %0d", extra, b),
                        (b == extra) ? 5'b11010 : 5'b10011);
        end
        drive(0, 3'd0, '0, 0, 0);
    endtask

    // R9: reserved class retires at once without popping.
    task automatic t_reserved();
        drive(1, 3'd7, 4'd3, 1, 1);
        expect_step("R9 reserved class", 5'b11000);
        drive(0, 3'd0, '0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dp();
        t_stores();
        t_single_load();
        t_pair_load();
        t_mem_load(0);
        t_mem_load(3);
        t_mem_load(15);
        t_pair_load();
        t_reserved();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #40000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule